// File: doc/BRIEF.md
# I2C Write-Only Bus Master

This block is a two-wire bus controller that only writes. The host gives it a 7-bit target address, a clock prescaler exponent and two clock divisors, one for the low phase and one for the high phase. It also gives a master enable and a NACK interrupt enable. Writing the transmit holding register while the bus is idle starts a transfer. The block sends a START, then the address byte with a zero direction bit, then each byte the host supplies. It checks the acknowledge after every byte. Clock and data are open-drain: each output is a pull-low enable.

Between bytes the controller does not end the transfer by itself. When a byte has been acknowledged and the host has written neither new data nor a stop command, it holds the clock low for as long as needed. A single-entry holding register with a pending flag decouples the host from the shifter. A ready flag tells the host when it may write the next byte. A sticky no-acknowledge flag, which can raise an interrupt, reports a target that refused a byte.

Top module: `i2c_tx_master`

## Requirements
- R1: After reset, both line enables are low (released), the ready flag is 1, and the NACK flag and the interrupt are 0.
- R2: A holding-register write while idle with the enable set makes the data line fall while the clock is released. The clock is pulled low one high phase later. With the enable clear, the bus stays released.
- R3: The first byte on the bus is the 7-bit target address, MSB first, followed by a direction bit that is always 0. Each bit is valid on the rising clock edge.
- R4: On the ninth clock of every byte the master releases the data line and samples it in the last cycle of the high phase. A low level means acknowledge.
- R5: A low phase lasts `lo_div * 2^clk_pre + 4` system clocks and a high phase lasts `hi_div * 2^clk_pre + 4` system clocks.
- R6: The ready flag drops in the cycle after a holding-register write. It rises when a byte is acknowledged and stays high until the next write.
- R7: After an acknowledged byte, a pending holding byte is loaded into the shifter and sent MSB first without a gap.
- R8: After an acknowledged byte with no pending data and no stop request, the clock is held low indefinitely. A later write releases it and sends the new byte.
- R9: A STOP is generated only after a stop command, once the current byte and its acknowledge are complete. The sequence is a low phase with data low, a high phase with data low, then the data line rises. A byte still pending when the stop begins is discarded. A stop command while idle has no effect.
- R10: A high acknowledge sets a sticky NACK flag. The interrupt equals the NACK flag ANDed with the interrupt enable. The clear strobe resets the flag.
- R11: After a NACK, the clock is held low and no further data byte is sent, even if the host writes one. Only a stop command ends the transfer.
- R12: The data line changes while the clock is released only for the START and the STOP. Each transfer shows exactly one of each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Master enable; gates the start of a transfer |
| tgt_addr | input | 7 | Target address sent in the first byte |
| clk_pre | input | PRE_W | Prescaler exponent applied to both divisors |
| lo_div | input | DIV_W | Clock low-phase divisor |
| hi_div | input | DIV_W | Clock high-phase divisor |
| nack_ie | input | 1 | NACK interrupt enable |
| thr_wr | input | 1 | Holding-register write strobe |
| thr_data | input | 8 | Byte written with `thr_wr` |
| stop_cmd | input | 1 | Stop command strobe |
| nack_clr | input | 1 | Clears the sticky NACK flag |
| sda_in | input | 1 | Sensed level of the data line |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| txrdy | output | 1 | Holding register may be written |
| nack | output | 1 | Sticky no-acknowledge flag |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume one-cycle strobes on `thr_wr`, `stop_cmd` and `nack_clr`. They also assume that the divisor and prescaler inputs stay constant while a transfer is in progress, and that `sda_in` is low only when the master or the target pulls it. The bench changes configuration only while the bus is idle and issues every strobe for exactly one cycle. Its target model pulls the data line only during the low phase before the ninth clock and releases it on the falling edge that ends the ninth clock. As a result, the sensed line never moves while the clock is released, except through the master's own START and STOP.

// File: rtl/i2c_tx_pkg.sv
package i2c_tx_pkg;

    // fixed overhead added to every clock phase, in system clocks
    localparam int unsigned PHASE_EXTRA = 4;
    // index of the acknowledge bit within a byte slot
    localparam logic [3:0]  ACK_IDX     = 4'd8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BLO,
        ST_BHI,
        ST_HOLD,
        ST_PLO,
        ST_PHI,
        ST_PFREE
    } bus_st_e;

    typedef struct packed {
        logic load;
        logic ack;
        logic nack;
        logic flush;
    } eng_evt_t;

    function automatic int unsigned phase_len(input int unsigned div,
                                              input int unsigned pre);
        return (div << pre) + PHASE_EXTRA;
    endfunction

endpackage

// File: rtl/i2c_tx_phase_timer.sv
module i2c_tx_phase_timer #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [LEN_W-1:0] len,
    output logic             last
);
    logic [LEN_W-1:0] cnt_q;

    assign last = (cnt_q == len - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (!last) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_tx_engine.sv
module i2c_tx_engine
    import i2c_tx_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [6:0]       addr,
    input  logic [LEN_W-1:0] lo_len,
    input  logic [LEN_W-1:0] hi_len,
    input  logic             pend,
    input  logic [7:0]       hold_byte,
    input  logic             stop_req,
    input  logic             sda_in,
    output logic             scl_oe,
    output logic             sda_oe,
    output eng_evt_t         evt,
    output bus_st_e          st_o
);
    bus_st_e    st_q, st_d;
    logic [7:0] sh_q, sh_d;
    logic [3:0] bit_q, bit_d;
    logic       abort_q, abort_d;
    logic       ph_last;
    logic [LEN_W-1:0] ph_len;

    assign ph_len = (st_q == ST_BLO || st_q == ST_PLO) ? lo_len : hi_len;

    i2c_tx_phase_timer #(.LEN_W(LEN_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (st_d != st_q),
        .len     (ph_len),
        .last    (ph_last)
    );

    always_comb begin
        st_d    = st_q;
        sh_d    = sh_q;
        bit_d   = bit_q;
        abort_d = abort_q;
        evt     = '0;
        unique case (st_q)
            ST_IDLE: begin
                if (en && pend) begin
                    st_d    = ST_START;
                    sh_d    = {addr, 1'b0};
                    bit_d   = '0;
                    abort_d = 1'b0;
                end
            end
            ST_START: if (ph_last) st_d = ST_BLO;
            ST_BLO:   if (ph_last) st_d = ST_BHI;
            ST_BHI: begin
                if (ph_last) begin
                    if (bit_q != ACK_IDX) begin
                        sh_d  = {sh_q[6:0], 1'b0};
                        bit_d = bit_q + 1'b1;
                        st_d  = ST_BLO;
                    end else begin
                        if (sda_in) begin
                            evt.nack = 1'b1;
                            abort_d  = 1'b1;
                        end else begin
                            evt.ack = 1'b1;
                        end
                        if (stop_req) begin
                            st_d      = ST_PLO;
                            evt.flush = 1'b1;
                        end else if (!sda_in && pend) begin
                            st_d     = ST_BLO;
                            sh_d     = hold_byte;
                            bit_d    = '0;
                            evt.load = 1'b1;
                        end else begin
                            st_d = ST_HOLD;
                        end
                    end
                end
            end
            ST_HOLD: begin
                if (stop_req) begin
                    st_d      = ST_PLO;
                    evt.flush = 1'b1;
                end else if (pend && !abort_q) begin
                    st_d     = ST_BLO;
                    sh_d     = hold_byte;
                    bit_d    = '0;
                    evt.load = 1'b1;
                end
            end
            ST_PLO:   if (ph_last) st_d = ST_PHI;
            ST_PHI:   if (ph_last) st_d = ST_PFREE;
            ST_PFREE: if (ph_last) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            sh_q    <= '0;
            bit_q   <= '0;
            abort_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            sh_q    <= sh_d;
            bit_q   <= bit_d;
            abort_q <= abort_d;
        end
    end

    // line drive decoded from registered state only
    assign scl_oe = (st_q == ST_BLO) || (st_q == ST_HOLD) || (st_q == ST_PLO);
    assign sda_oe = (st_q == ST_START) || (st_q == ST_PLO) || (st_q == ST_PHI) ||
                    (((st_q == ST_BLO) || (st_q == ST_BHI)) &&
                     (bit_q != ACK_IDX) && !sh_q[7]);
    assign st_o   = st_q;
endmodule

// File: rtl/i2c_tx_hostregs.sv
module i2c_tx_hostregs
    import i2c_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       thr_wr,
    input  logic [7:0] thr_data,
    input  logic       stop_cmd,
    input  logic       nack_clr,
    input  logic       nack_ie,
    input  logic       busy,
    input  eng_evt_t   evt,
    output logic [7:0] hold_byte,
    output logic       pend,
    output logic       stop_req,
    output logic       txrdy,
    output logic       nack,
    output logic       irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_byte <= '0;
            pend      <= 1'b0;
            stop_req  <= 1'b0;
            txrdy     <= 1'b1;
            nack      <= 1'b0;
        end else begin
            if (thr_wr) hold_byte <= thr_data;
            pend <= thr_wr || (pend && !(evt.load || evt.flush));

            if (thr_wr)       txrdy <= 1'b0;
            else if (evt.ack) txrdy <= 1'b1;

            if (evt.nack)     nack <= 1'b1;
            else if (nack_clr) nack <= 1'b0;

            if (evt.flush)             stop_req <= 1'b0;
            else if (stop_cmd && busy) stop_req <= 1'b1;
        end
    end

    assign irq = nack && nack_ie;
endmodule

// File: rtl/i2c_tx_master.sv
module i2c_tx_master
    import i2c_tx_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [6:0]       tgt_addr,
    input  logic [PRE_W-1:0] clk_pre,
    input  logic [DIV_W-1:0] lo_div,
    input  logic [DIV_W-1:0] hi_div,
    input  logic             nack_ie,
    input  logic             thr_wr,
    input  logic [7:0]       thr_data,
    input  logic             stop_cmd,
    input  logic             nack_clr,
    input  logic             sda_in,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             txrdy,
    output logic             nack,
    output logic             irq
);
    localparam int LEN_W = DIV_W + (1 << PRE_W);

    logic [LEN_W-1:0] lo_len, hi_len;
    logic [7:0]       hold_w;
    logic             pend_w, stop_req_w;
    eng_evt_t         evt_w;
    bus_st_e          eng_st;

    assign lo_len = LEN_W'(phase_len(32'(lo_div), 32'(clk_pre)));
    assign hi_len = LEN_W'(phase_len(32'(hi_div), 32'(clk_pre)));

    i2c_tx_hostregs u_regs (
        .clk       (clk),
        .rst       (rst),
        .thr_wr    (thr_wr),
        .thr_data  (thr_data),
        .stop_cmd  (stop_cmd),
        .nack_clr  (nack_clr),
        .nack_ie   (nack_ie),
        .busy      (eng_st != ST_IDLE),
        .evt       (evt_w),
        .hold_byte (hold_w),
        .pend      (pend_w),
        .stop_req  (stop_req_w),
        .txrdy     (txrdy),
        .nack      (nack),
        .irq       (irq)
    );

    i2c_tx_engine #(.LEN_W(LEN_W)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .addr      (tgt_addr),
        .lo_len    (lo_len),
        .hi_len    (hi_len),
        .pend      (pend_w),
        .hold_byte (hold_w),
        .stop_req  (stop_req_w),
        .sda_in    (sda_in),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .evt       (evt_w),
        .st_o      (eng_st)
    );
endmodule

// File: rtl/i2c_tx_master_chk.sv
module i2c_tx_master_chk
    import i2c_tx_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    thr_wr,
    input logic    nack_clr,
    input logic    scl_oe,
    input logic    sda_oe,
    input logic    txrdy,
    input logic    nack,
    input bus_st_e st,
    input logic    pend,
    input logic    stop_req
);
    // R6
    ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (txrdy && !thr_wr) |=> txrdy);

    // R6
    ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        thr_wr |=> !txrdy);

    // R10
    nack_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (nack && !nack_clr) |=> nack);

    // R12
    start_only_chk: assert property (@(posedge clk) disable iff (rst)
        (!scl_oe && !$past(scl_oe) && $rose(sda_oe)) |-> (st == ST_START));

    // R12
    stop_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (!scl_oe && !$past(scl_oe) && $fell(sda_oe)) |-> (st == ST_PFREE));

    // R9
    stop_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PLO && $past(st) != ST_PLO) |-> $past(stop_req));

    // R8
    hold_exit_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == ST_HOLD && st != ST_HOLD) |-> ($past(pend) || $past(stop_req)));
endmodule

bind i2c_tx_master i2c_tx_master_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .thr_wr   (thr_wr),
    .nack_clr (nack_clr),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .txrdy    (txrdy),
    .nack     (nack),
    .st       (eng_st),
    .pend     (pend_w),
    .stop_req (stop_req_w)
);

// File: tb/i2c_tx_master_test.sv
module i2c_tx_master_test;
    localparam int DIV_W = 8;
    localparam int PRE_W = 3;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst = 1'b1;
    logic             en = 1'b0;
    logic [6:0]       tgt_addr = '0;
    logic [PRE_W-1:0] clk_pre = '0;
    logic [DIV_W-1:0] lo_div = '0;
    logic [DIV_W-1:0] hi_div = '0;
    logic             nack_ie = 1'b0;
    logic             thr_wr = 1'b0;
    logic [7:0]       thr_data = '0;
    logic             stop_cmd = 1'b0;
    logic             nack_clr = 1'b0;
    logic             scl_oe, sda_oe, txrdy, nack, irq;
    logic             slv_pull = 1'b0;
    logic             scl_line, sda_line;

    assign scl_line = !scl_oe;
    assign sda_line = !(sda_oe || slv_pull);

    i2c_tx_master #(.DIV_W(DIV_W), .PRE_W(PRE_W)) uut (
        .clk(clk), .rst(rst), .en(en), .tgt_addr(tgt_addr), .clk_pre(clk_pre),
        .lo_div(lo_div), .hi_div(hi_div), .nack_ie(nack_ie), .thr_wr(thr_wr),
        .thr_data(thr_data), .stop_cmd(stop_cmd), .nack_clr(nack_clr),
        .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe), .txrdy(txrdy),
        .nack(nack), .irq(irq)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // ---------------- bus monitor and target model ----------------
    bit         mon_clr = 0;
    int         nack_at = -1;
    int         cyc = 0, fall_t = 0, rise_t = 0, start_t = 0;
    int         lo_min, lo_max, hi_min, hi_max;
    int         start_hold = 0, stop_hold = 0;
    int         n_start = 0, n_stop = 0, n_bytes = 0, rel_err = 0;
    int         bitpos = 0;
    bit         got_bit = 0;
    logic       scl_p = 1'b1, sda_p = 1'b1;
    logic [7:0] sh = '0;
    logic [7:0] rx [0:15];

    always @(negedge clk) begin
        cyc++;
        if (mon_clr) begin
            lo_min = 1 << 30; lo_max = 0; hi_min = 1 << 30; hi_max = 0;
            start_hold = 0; stop_hold = 0; n_start = 0; n_stop = 0;
            n_bytes = 0; rel_err = 0; bitpos = 0; got_bit = 0; slv_pull = 1'b0;
        end else begin
            if (scl_p && scl_line && sda_p && !sda_line) begin
                n_start++; start_t = cyc; bitpos = 0; got_bit = 0;
            end else if (scl_p && scl_line && !sda_p && sda_line) begin
                n_stop++; stop_hold = cyc - rise_t; bitpos = 0; got_bit = 0;
            end
            if (!scl_p && scl_line) begin
                rise_t = cyc;
                if (bitpos != 0) begin
                    if (cyc - fall_t < lo_min) lo_min = cyc - fall_t;
                    if (cyc - fall_t > lo_max) lo_max = cyc - fall_t;
                end
                if (bitpos < 8) sh = {sh[6:0], sda_line};
                else if (sda_oe) rel_err++;
                got_bit = 1;
            end
            if (scl_p && !scl_line) begin
                fall_t = cyc;
                if (got_bit) begin
                    if (cyc - rise_t < hi_min) hi_min = cyc - rise_t;
                    if (cyc - rise_t > hi_max) hi_max = cyc - rise_t;
                    got_bit = 0;
                    if (bitpos == 7) begin
                        if (n_bytes < 16) rx[n_bytes] = sh;
                        slv_pull = (n_bytes != nack_at);
                        n_bytes++;
                        bitpos = 8;
                    end else if (bitpos == 8) begin
                        slv_pull = 1'b0;
                        bitpos = 0;
                    end else begin
                        bitpos++;
                    end
                end else begin
                    start_hold = cyc - start_t;
                end
            end
        end
        scl_p = scl_line;
        sda_p = sda_line;
    end

    // ---------------- helpers ----------------
    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        mon_clr = 1;
        tick(1);
        mon_clr = 0;
    endtask

    task automatic wr(input logic [7:0] d);
        thr_data = d;
        thr_wr = 1'b1;
        tick(1);
        thr_wr = 1'b0;
    endtask

    task automatic stop_pulse();
        stop_cmd = 1'b1;
        tick(1);
        stop_cmd = 1'b0;
    endtask

    task automatic wait_rdy();
        tick(1);
        while (!txrdy) tick(1);
    endtask

    task automatic wait_bytes(input int n);
        while (n_bytes < n) tick(1);
    endtask

    task automatic wait_stop();
        while (n_stop < 1) tick(1);
        tick(60);
    endtask

    function automatic logic [7:0] dbyte(input int base, input int i);
        return 8'(base + i * 61);
    endfunction

    // full write transfer with nd data bytes, then stop
    task automatic xfer(input int nd, input int base);
        int lo_exp, hi_exp;
        lo_exp = (int'(lo_div) << clk_pre) + 4;
        hi_exp = (int'(hi_div) << clk_pre) + 4;
        clear_mon();
        wr(dbyte(base, 0));
        for (int i = 1; i < nd; i++) begin
            wait_rdy();
            wr(dbyte(base, i));
        end
        wait_rdy();
        stop_pulse();
        wait_stop();
        chk("R12 start count", n_start, 1);
        chk("R9 stop count", n_stop, 1);
        chk("R3 bytes on bus", n_bytes, nd + 1);
        chk("R3 address byte", int'(rx[0]), int'({tgt_addr, 1'b0}));
        for (int i = 0; i < nd; i++)
            chk("R7 data byte", int'(rx[i + 1]), int'(dbyte(base, i)));
        chk("R5 low phase min", lo_min, lo_exp);
        chk("R5 low phase max", lo_max, lo_exp);
        chk("R5 high phase min", hi_min, hi_exp);
        chk("R5 high phase max", hi_max, hi_exp);
        chk("R2 start hold", start_hold, hi_exp);
        chk("R9 stop hold", stop_hold, hi_exp);
        chk("R4 ninth bit released", rel_err, 0);
        chk("R6 ready after ack", int'(txrdy), 1);
        chk("R9 bus released after stop", int'(scl_oe || sda_oe), 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        tick(5);
        rst = 1'b0;
        tick(1);
        // R1
        chk("R1 scl released", int'(scl_oe), 0);
        chk("R1 sda released", int'(sda_oe), 0);
        chk("R1 ready", int'(txrdy), 1);
        chk("R1 nack", int'(nack), 0);
        chk("R1 irq", int'(irq), 0);

        // R9: stop command while idle does nothing
        clear_mon();
        stop_pulse();
        tick(200);
        chk("R9 idle stop ignored starts", n_start, 0);
        chk("R9 idle stop ignored stops", n_stop, 0);
        chk("R9 idle stop bus", int'(scl_oe || sda_oe), 0);

        // R2: write with master disabled leaves the bus idle
        tgt_addr = 7'h2A; clk_pre = 0; lo_div = 2; hi_div = 1;
        clear_mon();
        wr(8'hC3);
        tick(200);
        chk("R2 disabled no start", n_start, 0);
        chk("R2 disabled bus idle", int'(scl_oe || sda_oe), 0);
        en = 1'b1;
        wait_rdy();
        stop_pulse();
        wait_stop();
        chk("R2 enable starts pending", n_start, 1);
        chk("R2 pending address", int'(rx[0]), int'({7'h2A, 1'b0}));
        chk("R2 pending data", int'(rx[1]), 8'hC3);

        // R3 R5 R7 R12: sweep of timing configurations
        for (int p = 0; p < 3; p++)
            for (int l = 0; l < 2; l++)
                for (int h = 0; h < 2; h++) begin
                    clk_pre  = PRE_W'(p);
                    lo_div   = (l != 0) ? 8'd3 : 8'd0;
                    hi_div   = (h != 0) ? 8'd4 : 8'd1;
                    tgt_addr = 7'(8'h11 + (p * 4 + l * 2 + h) * 23);
                    xfer(1 + ((p + l + h) % 3), 17 * (p * 4 + l * 2 + h) + 5);
                end

        // R8: clock stretching until new data, then stop
        clk_pre = 0; lo_div = 3; hi_div = 2; tgt_addr = 7'h50;
        clear_mon();
        wr(8'hA5);
        wait_bytes(2);
        tick(300);
        chk("R8 clock held low", int'(scl_oe), 1);
        chk("R8 ready while held", int'(txrdy), 1);
        chk("R8 no stop while held", n_stop, 0);
        chk("R8 no extra byte", n_bytes, 2);
        wr(8'h3C);
        chk("R6 ready drops after write", int'(txrdy), 0);
        wait_bytes(3);
        chk("R8 byte after release", int'(rx[2]), 8'h3C);
        wait_rdy();
        stop_pulse();
        wait_stop();
        chk("R9 stop after held transfer", n_stop, 1);
        chk("R12 single start", n_start, 1);

        // R10 R11: refused data byte with interrupt enabled
        nack_ie = 1'b1;
        nack_at = 1;
        clear_mon();
        wr(8'h77);
        wait_bytes(2);
        tick(60);
        chk("R10 nack set", int'(nack), 1);
        chk("R10 irq raised", int'(irq), 1);
        chk("R11 clock held after nack", int'(scl_oe), 1);
        wr(8'h99);
        tick(300);
        chk("R11 no byte after nack", n_bytes, 2);
        chk("R11 still held", int'(scl_oe), 1);
        stop_pulse();
        wait_stop();
        chk("R11 stop ends nack transfer", n_stop, 1);
        chk("R9 pending byte discarded", n_start, 1);
        chk("R10 nack sticky", int'(nack), 1);
        nack_clr = 1'b1;
        tick(1);
        nack_clr = 1'b0;
        chk("R10 nack cleared", int'(nack), 0);
        chk("R10 irq cleared", int'(irq), 0);

        // R4 R10: refused address with interrupt disabled
        nack_ie = 1'b0;
        nack_at = 0;
        tgt_addr = 7'h0F;
        clear_mon();
        wr(8'h12);
        wait_bytes(1);
        tick(60);
        chk("R4 address nack seen", int'(nack), 1);
        chk("R10 irq masked", int'(irq), 0);
        tick(300);
        chk("R11 no data after address nack", n_bytes, 1);
        stop_pulse();
        wait_stop();
        chk("R9 stop after address nack", n_stop, 1);
        nack_clr = 1'b1;
        tick(1);
        nack_clr = 1'b0;
        chk("R10 nack cleared again", int'(nack), 0);
        nack_at = -1;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule